// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers interrupt lines for a processor. It has two local groups of eight sources each. Every local group has a readable status byte and a writable mask byte. A local group asserts its processor interrupt output whenever a status bit is pending and the matching mask bit is set.

A third set of eight mappable sources has one status byte and two independent mask bytes. The gated OR under each mask becomes a single bit inside a local group, which makes a two-level cascade:

- mask A feeds bit 7 of local group 0;
- mask B feeds bit 3 of local group 1.

Two timer pulse inputs each set a sticky latch on a rising edge. Each latch drives a dedicated timer interrupt output until software clears it with a write to the timer-clear register. A parameter selects an older variant in which local status is active-low.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Status reads return the live input levels and have no side effects. Local group 0 status is at address 0, local group 1 status at address 2, and mappable status at address 4. Reading any of them twice gives the same value.
- R2: `cpu_irq_o[g]` is 1 exactly when (status AND mask) of local group g is nonzero. The output is registered, so it follows a status or mask change one clock later.
- R3: The mask bytes are read/write. Local group 0 mask is at address 1, local group 1 mask at address 3, mappable mask A at address 5 and mappable mask B at address 6. All four read 0 after reset.
- R4: Bit 7 of local group 0 status is the OR of (mappable status AND mask A).
- R5: Bit 3 of local group 1 status is the OR of (mappable status AND mask B).
- R6: The raw local input lines at the two cascade positions (group 0 bit 7, group 1 bit 3) have no effect on status or on `cpu_irq_o`.
- R7: A rising edge on `tmr_pulse_i[t]` sets timer latch t. The latch is shown on `tmr_irq_o[t]` from the same clock edge and stays set while no clear arrives.
- R8: A write to address 7 clears timer latch 0 when data bit 0 is 1 and timer latch 1 when data bit 1 is 1, so 0x03 clears both. A pulse input held high does not set the latch again after a clear.
- R9: With `ACTIVE_LOW`=1, a local status bit of 0 means pending: pending = (NOT status) AND mask, and the cascade bits are shown inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | W | Write data |
| reg_rdata_o | output | W | Read data for `reg_addr_i` (combinational) |
| loc0_irq_i | input | W | Raw lines of local group 0 |
| loc1_irq_i | input | W | Raw lines of local group 1 |
| map_irq_i | input | W | Raw mappable lines |
| tmr_pulse_i | input | 2 | Timer outputs, edge sensitive |
| cpu_irq_o | output | 2 | Processor interrupt per local group |
| tmr_irq_o | output | 2 | Timer interrupt latches |

## Verification
The hardest situation to reach is a cascade bit whose raw local line disagrees with the mappable summary. The stimulus drives local line 7 high while mask A is zero, then reverses the case, and compares both the status byte and the processor output. The second hard case is a timer pulse that stays high across a clear. The stimulus holds the pulse level through the clear write and checks that no new edge is seen. A second instance built with the active-low option checks the inverted pending rule.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  typedef enum logic [2:0] {
    RA_L0_STAT   = 3'd0,
    RA_L0_MASK   = 3'd1,
    RA_L1_STAT   = 3'd2,
    RA_L1_MASK   = 3'd3,
    RA_MAP_STAT  = 3'd4,
    RA_MAP_MASKA = 3'd5,
    RA_MAP_MASKB = 3'd6,
    RA_TMR_CLR   = 3'd7
  } reg_addr_e;

  localparam int NUM_GROUPS = 2;
  localparam int NUM_TIMERS = 2;

  function automatic reg_addr_e loc_mask_addr(input int g);
    return (g == 0) ? RA_L0_MASK : RA_L1_MASK;
  endfunction

  function automatic reg_addr_e map_mask_addr(input int g);
    return (g == 0) ? RA_MAP_MASKA : RA_MAP_MASKB;
  endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pend_i,
  output logic [W-1:0] mask_o,
  output logic         any_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
  assign any_o  = |(pend_i & mask_q);

  // R3
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mask_q == $past(wdata_i));
  // R3
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_tmr_latch.sv
module irq_tmr_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pulse_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] prev_q, lat_q, rise;

  assign rise = pulse_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= pulse_i;
      lat_q  <= (lat_q & ~clr_i) | rise;  // new edge beats a clear
    end
  end

  assign irq_o = lat_q;

  for (genvar t = 0; t < N; t++) begin : g_chk
    // R7
    tmr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[t] |=> lat_q[t]);
    // R7
    tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[t] && !clr_i[t]) |=> lat_q[t]);
    // R8
    tmr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[t] && !rise[t]) |=> !lat_q[t]);
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int W          = 8,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int CASC0_BIT  = 7,
  parameter int CASC1_BIT  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [W-1:0]          reg_wdata_i,
  output logic [W-1:0]          reg_rdata_o,
  input  logic [W-1:0]          loc0_irq_i,
  input  logic [W-1:0]          loc1_irq_i,
  input  logic [W-1:0]          map_irq_i,
  input  logic [NUM_TIMERS-1:0] tmr_pulse_i,
  output logic [NUM_GROUPS-1:0] cpu_irq_o,
  output logic [NUM_TIMERS-1:0] tmr_irq_o
);
  logic [NUM_GROUPS-1:0][W-1:0] loc_stat, loc_mask, map_mask;
  logic [NUM_GROUPS-1:0]        map_sum, loc_any;
  logic [NUM_GROUPS-1:0]        cpu_irq_q;
  logic [NUM_TIMERS-1:0]        tmr_clr;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int CB = (g == 0) ? CASC0_BIT : CASC1_BIT;
    logic [W-1:0] raw_g, stat_g, pend_g;

    irq_group #(.W(W)) u_map (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(reg_wr_i && (reg_addr_i == map_mask_addr(g))),
      .wdata_i(reg_wdata_i),
      .pend_i (map_irq_i),
      .mask_o (map_mask[g]),
      .any_o  (map_sum[g])
    );

    assign raw_g = (g == 0) ? loc0_irq_i : loc1_irq_i;

    // cascade slot replaces the raw line, shown in the group's polarity
    always_comb begin
      stat_g     = raw_g;
      stat_g[CB] = ACTIVE_LOW ? ~map_sum[g] : map_sum[g];
    end

    assign pend_g      = ACTIVE_LOW ? ~stat_g : stat_g;
    assign loc_stat[g] = stat_g;

    irq_group #(.W(W)) u_loc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(reg_wr_i && (reg_addr_i == loc_mask_addr(g))),
      .wdata_i(reg_wdata_i),
      .pend_i (pend_g),
      .mask_o (loc_mask[g]),
      .any_o  (loc_any[g])
    );

    // R4 R5
    casc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((map_irq_i & map_mask[g]) == '0) |-> (stat_g[CB] == ACTIVE_LOW));
    // R2
    cpu_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (cpu_irq_o[g] == $past(loc_any[g])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_irq_q <= '0;
    else         cpu_irq_q <= loc_any;
  end
  assign cpu_irq_o = cpu_irq_q;

  assign tmr_clr = (reg_wr_i && (reg_addr_i == RA_TMR_CLR)) ?
                   reg_wdata_i[NUM_TIMERS-1:0] : '0;

  irq_tmr_latch #(.N(NUM_TIMERS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(tmr_pulse_i),
    .clr_i  (tmr_clr),
    .irq_o  (tmr_irq_o)
  );

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      RA_L0_STAT:   reg_rdata_o = loc_stat[0];
      RA_L0_MASK:   reg_rdata_o = loc_mask[0];
      RA_L1_STAT:   reg_rdata_o = loc_stat[1];
      RA_L1_MASK:   reg_rdata_o = loc_mask[1];
      RA_MAP_STAT:  reg_rdata_o = map_irq_i;
      RA_MAP_MASKA: reg_rdata_o = map_mask[0];
      RA_MAP_MASKB: reg_rdata_o = map_mask[1];
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0, reg_wr1 = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] rdata0, rdata1;
  logic [W-1:0] loc0 = '0, loc1 = '0, mapi = '0;
  logic [W-1:0] loc0_b = 8'hFF, loc1_b = 8'hFF;
  logic [1:0]   pulse = '0;
  logic [1:0]   cpu0, tmr0, cpu1, tmr1;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [1:0] cpu;
    logic [1:0] tmr;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irq_cascade_ctrl #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata0), .loc0_irq_i(loc0),
    .loc1_irq_i(loc1), .map_irq_i(mapi), .tmr_pulse_i(pulse),
    .cpu_irq_o(cpu0), .tmr_irq_o(tmr0)
  );

  irq_cascade_ctrl #(.W(W), .ACTIVE_LOW(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr1),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata1), .loc0_irq_i(loc0_b),
    .loc1_irq_i(loc1_b), .map_irq_i(8'h00), .tmr_pulse_i(2'b00),
    .cpu_irq_o(cpu1), .tmr_irq_o(tmr1)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      total++;
      if (cpu0 !== e.cpu || tmr0 !== e.tmr) begin
        bad++;
        $display("FAIL %s: cpu=%b tmr=%b expected cpu=%b tmr=%b",
                 e.tag, cpu0, tmr0, e.cpu, e.tmr);
      end
    end
  end

  task automatic tick(input logic [1:0] cpu, input logic [1:0] tmr, input string tag);
    exp_t e;
    @(posedge clk);
    e.cpu = cpu; e.tmr = tmr; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input bit second = 1'b0);
    @(negedge clk);
    #1;
    reg_addr = a; reg_wdata = d;
    if (second) reg_wr1 = 1'b1; else reg_wr = 1'b1;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_wr1 = 1'b0;
  endtask

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag,
                    input bit second = 1'b0);
    reg_addr = a;
    #1;
    chk(second ? rdata1 : rdata0, exp, tag);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick(2'b00, 2'b00, "R2 reset outputs");
    rd(3'd1, 8'h00, "R3 reset l0 mask");
    rd(3'd3, 8'h00, "R3 reset l1 mask");
    rd(3'd5, 8'h00, "R3 reset mask A");
    rd(3'd6, 8'h00, "R3 reset mask B");

    // local group 0
    loc0 = 8'h05;
    rd(3'd0, 8'h05, "R1 l0 status");
    tick(2'b00, 2'b00, "R2 all masked");
    wr(3'd1, 8'h04);
    rd(3'd1, 8'h04, "R3 l0 mask readback");
    tick(2'b01, 2'b00, "R2 l0 unmasked");
    wr(3'd2 + 3'd0 + 3'd1 - 3'd2, 8'h02); // address 1
    tick(2'b00, 2'b00, "R2 l0 mask misses");

    // local group 1
    loc1 = 8'h30;
    wr(3'd3, 8'h20);
    rd(3'd2, 8'h30, "R1 l1 status");
    tick(2'b10, 2'b00, "R2 l1 unmasked");
    loc1 = 8'h00;
    tick(2'b00, 2'b00, "R2 l1 line drops");

    // cascade into group 0 bit 7
    wr(3'd1, 8'h80);
    loc0 = 8'h85;
    rd(3'd0, 8'h05, "R6 raw l0 bit7 ignored");
    tick(2'b00, 2'b00, "R6 raw l0 bit7 no irq");
    mapi = 8'h10;
    wr(3'd5, 8'h10);
    rd(3'd0, 8'h85, "R4 mask A summary in l0 bit7");
    rd(3'd4, 8'h10, "R1 map status");
    rd(3'd4, 8'h10, "R1 map status reread");
    tick(2'b01, 2'b00, "R4 cascade to cpu0");
    mapi = 8'h20;
    rd(3'd0, 8'h05, "R4 unselected map line");
    tick(2'b00, 2'b00, "R4 cascade clears");

    // cascade into group 1 bit 3
    wr(3'd6, 8'h20);
    wr(3'd3, 8'h08);
    rd(3'd2, 8'h08, "R5 mask B summary in l1 bit3");
    tick(2'b10, 2'b00, "R5 cascade to cpu1");
    wr(3'd6, 8'h00);
    loc1 = 8'h08;
    rd(3'd2, 8'h00, "R6 raw l1 bit3 ignored");
    tick(2'b00, 2'b00, "R6 raw l1 bit3 no irq");

    // timers
    pulse = 2'b01;
    tick(2'b00, 2'b01, "R7 timer0 edge");
    tick(2'b00, 2'b01, "R7 timer0 held");
    wr(3'd7, 8'h01);
    tick(2'b00, 2'b00, "R8 clear bit0, level held high");
    pulse = 2'b11;
    tick(2'b00, 2'b10, "R7 timer1 edge");
    pulse = 2'b00;
    tick(2'b00, 2'b10, "R7 timer1 held");
    pulse = 2'b01;
    tick(2'b00, 2'b11, "R7 timer0 new edge");
    wr(3'd7, 8'h02);
    tick(2'b00, 2'b01, "R8 clear bit1 only");
    pulse = 2'b00;
    tick(2'b00, 2'b01, "R8 latch kept");
    pulse = 2'b10;
    tick(2'b00, 2'b11, "R7 both set");
    wr(3'd7, 8'h03);
    tick(2'b00, 2'b00, "R8 clear both");

    // active-low variant
    wr(3'd1, 8'h01, 1'b1);
    @(posedge clk); @(negedge clk);
    chk({6'd0, cpu1}, 8'h00, "R9 all lines idle high");
    loc0_b = 8'hFE;
    rd(3'd0, 8'hFE, "R9 status shows raw low", 1'b1);
    @(posedge clk); @(negedge clk);
    chk({6'd0, cpu1}, 8'h01, "R9 low bit pending");
    loc0_b = 8'hFD;
    @(posedge clk); @(negedge clk);
    chk({6'd0, cpu1}, 8'h00, "R9 masked low bit");
    rd(3'd2, 8'hFF, "R9 cascade bit inverted idle", 1'b1);

    repeat (2) @(posedge clk);
    summary();
  end
endmodule